// File: doc/BRIEF.md
# DSP Data RAM Longword Transfer Engine

This block moves 32-bit longwords between a banked on-chip data RAM and an external memory bus, in either direction. Software prepares a transfer in two register writes: it preloads the address counter of one RAM bank, then loads either the external read base or the external write base. A start command then names the direction, the bank, a coded external address step and a hold flag. The busy flag rises and stays up for as long as the transfer runs.

The transfer length is not counted inside the block. Each external ready strobe moves exactly one longword. An external end strobe stops the transfer. After every longword the bank counter advances by one and the external address advances by the programmed step. A separate host port writes and reads the RAM words directly, so that software can stage outgoing data and inspect incoming data.

Top module: `dram_xfer_engine`

## Requirements
- R1: A start command (`cmd_start`) given while idle raises `busy` from the next cycle. It latches the direction, bank, step code and hold flag, and it places the selected base address on `ext_addr`.
- R2: In each active cycle with `ext_ready` high and `ext_end` low, one longword moves. With direction 0 (external to RAM), `ext_rdata` is written into the selected bank at its counter. With direction 1 (RAM to external), the word at the bank counter appears on `ext_wdata` with `ext_wr_en` high in that same cycle.
- R3: While a transfer is active, `ext_end` drops `busy` in the same cycle. No longword moves in a cycle where `ext_end` is high.
- R4: Each moved longword increments the counter of the selected bank by one. The counter wraps from 63 to 0, and it keeps its value from one transfer to the next.
- R5: Each moved longword adds the decoded step to the running external address on `ext_addr`.
- R6: The step code maps to a byte increment as follows: code 0 gives 0, and code k in 1..7 gives 2^(k-1), i.e. 1, 2, 4, 8, 16, 32 or 64.
- R7: `addr_wr` with `addr_sel`=0 loads the read base (`rd_base`) and with `addr_sel`=1 loads the write base (`wr_base`). Direction 0 starts from the read base and direction 1 starts from the write base.
- R8: At the end of a transfer with hold=0, the final running address is written back into the base register that the transfer used. With hold=1, both bases keep their values.
- R9: `ctr_wr` loads `ctr_val` into the counter of bank `ctr_bank`, and the next transfer on that bank starts there.
- R10: A start command that arrives while a transfer is active is ignored. The running transfer keeps its direction, bank, step and address.
- R11: An `ext_ready` strobe that arrives while idle is ignored: the RAM is not written, no counter moves, and `ext_wr_en` stays low.
- R12: After reset `busy` is low, both bases are zero and every bank counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctr_wr | input | 1 | Load a bank counter |
| ctr_bank | input | 2 | Bank whose counter is loaded |
| ctr_val | input | 6 | Counter preload value |
| addr_wr | input | 1 | Load an external base register |
| addr_sel | input | 1 | 0 = read base, 1 = write base |
| addr_val | input | 32 | Base address value |
| cmd_start | input | 1 | Start command strobe |
| cmd_dir | input | 1 | 0 = external to RAM, 1 = RAM to external |
| cmd_bank | input | 2 | RAM bank used by the transfer |
| cmd_step | input | 3 | Coded external address step |
| cmd_hold | input | 1 | Keep base registers unchanged at end |
| ext_ready | input | 1 | External data-ready strobe, one longword each |
| ext_end | input | 1 | External end-of-transfer strobe |
| ext_rdata | input | 32 | Longword read from external memory |
| host_we | input | 1 | Host RAM write enable |
| host_bank | input | 2 | Host write bank |
| host_addr | input | 6 | Host write word address |
| host_wdata | input | 32 | Host write data |
| host_rbank | input | 2 | Host read bank |
| host_raddr | input | 6 | Host read word address |
| host_rdata | output | 32 | Host read data (combinational) |
| ext_addr | output | 32 | Running external byte address |
| ext_wdata | output | 32 | Longword sent to external memory |
| ext_wr_en | output | 1 | External write strobe |
| busy | output | 1 | Transfer in progress |
| rd_base | output | 32 | External read base register |
| wr_base | output | 32 | External write base register |

## Verification
The bench drives a counter preload near the top of a bank so that the transfer crosses the 63-to-0 wrap. A design without the wrap would write past the bank or into a neighbouring bank, and the host readback sweep would show the misplaced words. Every step code, including 0 and 7, is used in both directions and with both hold values. A wrong decode or a missing writeback shows up on `ext_addr` or on the base registers. Start commands during a transfer and ready strobes while idle are injected. A design that obeyed them would change the running address mid-transfer, or would corrupt RAM and counters, which the following transfers and sweeps expose.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
    localparam int AW      = 32;
    localparam int DW      = 32;
    localparam int NBANK   = 4;
    localparam int BDEPTH  = 64;
    localparam int BANK_W  = $clog2(NBANK);
    localparam int PTR_W   = $clog2(BDEPTH);
    localparam int STEP_W  = 3;

    typedef enum logic {
        DIR_EXT_TO_RAM = 1'b0,
        DIR_RAM_TO_EXT = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        xfer_dir_e          dir;
        logic [BANK_W-1:0]  bank;
        logic [STEP_W-1:0]  step;
        logic               hold;
    } xfer_cmd_t;

    // code 0 -> no advance, code k -> 2^(k-1) bytes
    function automatic logic [AW-1:0] step_bytes(input logic [STEP_W-1:0] code);
        if (code == '0)
            return '0;
        return AW'(1) << (code - STEP_W'(1));
    endfunction
endpackage

// File: rtl/dxe_ctrl.sv
module dxe_ctrl
    import dxe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_start,
    input  xfer_cmd_t cmd_in,
    input  logic      ext_ready,
    input  logic      ext_end,
    output logic      run_q,
    output xfer_cmd_t cur,
    output logic      launch,
    output logic      beat,
    output logic      finish,
    output logic      busy
);
    assign launch = cmd_start & ~run_q;
    assign finish = run_q & ext_end;
    assign beat   = run_q & ext_ready & ~ext_end;
    assign busy   = run_q & ~ext_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cur   <= '0;
        end else if (finish) begin
            run_q <= 1'b0;
        end else if (launch) begin
            run_q <= 1'b1;
            cur   <= cmd_in;
        end
    end
endmodule

// File: rtl/dxe_addr_unit.sv
module dxe_addr_unit
    import dxe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_wr,
    input  logic          addr_sel,
    input  logic [AW-1:0] addr_val,
    input  logic          launch,
    input  xfer_dir_e     launch_dir,
    input  logic          beat,
    input  logic          finish,
    input  xfer_cmd_t     cur,
    output logic [AW-1:0] run_addr,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] wr_base
);
    logic          wb_rd;
    logic          wb_wr;

    assign wb_rd = finish & ~cur.hold & (cur.dir == DIR_EXT_TO_RAM);
    assign wb_wr = finish & ~cur.hold & (cur.dir == DIR_RAM_TO_EXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_base <= '0;
            wr_base <= '0;
        end else begin
            if (wb_rd)
                rd_base <= run_addr;
            else if (addr_wr && !addr_sel)
                rd_base <= addr_val;
            if (wb_wr)
                wr_base <= run_addr;
            else if (addr_wr && addr_sel)
                wr_base <= addr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_addr <= '0;
        else if (launch)
            run_addr <= (launch_dir == DIR_RAM_TO_EXT) ? wr_base : rd_base;
        else if (beat)
            run_addr <= run_addr + step_bytes(cur.step);
    end
endmodule

// File: rtl/dxe_bank_ram.sv
module dxe_bank_ram
    import dxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctr_wr,
    input  logic [BANK_W-1:0] ctr_bank,
    input  logic [PTR_W-1:0]  ctr_val,
    input  logic              beat,
    input  xfer_cmd_t         cur,
    input  logic [DW-1:0]     ext_rdata,
    input  logic              host_we,
    input  logic [BANK_W-1:0] host_bank,
    input  logic [PTR_W-1:0]  host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic [BANK_W-1:0] host_rbank,
    input  logic [PTR_W-1:0]  host_raddr,
    output logic [DW-1:0]     host_rdata,
    output logic [DW-1:0]     dma_rdata,
    output logic [PTR_W-1:0]  cur_ptr
);
    logic [PTR_W-1:0] ptr_q    [NBANK];
    logic [DW-1:0]    dma_word [NBANK];
    logic [DW-1:0]    host_word[NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [DW-1:0] mem [BDEPTH];
        logic          sel;
        logic          dma_fill;

        assign sel      = beat && (cur.bank == BANK_W'(g));
        assign dma_fill = sel && (cur.dir == DIR_EXT_TO_RAM);

        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[g] <= '0;
            else if (sel)
                ptr_q[g] <= ptr_q[g] + PTR_W'(1);
            else if (ctr_wr && ctr_bank == BANK_W'(g))
                ptr_q[g] <= ctr_val;
        end

        always_ff @(posedge clk) begin
            if (dma_fill)
                mem[ptr_q[g]] <= ext_rdata;
            else if (host_we && host_bank == BANK_W'(g))
                mem[host_addr] <= host_wdata;
        end

        assign dma_word[g]  = mem[ptr_q[g]];
        assign host_word[g] = mem[host_raddr];
    end

    assign dma_rdata  = dma_word[cur.bank];
    assign cur_ptr    = ptr_q[cur.bank];
    assign host_rdata = host_word[host_rbank];
endmodule

// File: rtl/dram_xfer_engine.sv
module dram_xfer_engine
    import dxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctr_wr,
    input  logic [BANK_W-1:0] ctr_bank,
    input  logic [PTR_W-1:0]  ctr_val,
    input  logic              addr_wr,
    input  logic              addr_sel,
    input  logic [AW-1:0]     addr_val,
    input  logic              cmd_start,
    input  logic              cmd_dir,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [STEP_W-1:0] cmd_step,
    input  logic              cmd_hold,
    input  logic              ext_ready,
    input  logic              ext_end,
    input  logic [DW-1:0]     ext_rdata,
    input  logic              host_we,
    input  logic [BANK_W-1:0] host_bank,
    input  logic [PTR_W-1:0]  host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic [BANK_W-1:0] host_rbank,
    input  logic [PTR_W-1:0]  host_raddr,
    output logic [DW-1:0]     host_rdata,
    output logic [AW-1:0]     ext_addr,
    output logic [DW-1:0]     ext_wdata,
    output logic              ext_wr_en,
    output logic              busy,
    output logic [AW-1:0]     rd_base,
    output logic [AW-1:0]     wr_base
);
    xfer_cmd_t        cmd_in;
    xfer_cmd_t        cur;
    logic             run_q;
    logic             launch;
    logic             beat;
    logic             finish;
    logic [AW-1:0]    run_addr;
    logic [DW-1:0]    dma_rdata;
    logic [PTR_W-1:0] cur_ptr;

    assign cmd_in = '{dir:  xfer_dir_e'(cmd_dir),
                      bank: cmd_bank,
                      step: cmd_step,
                      hold: cmd_hold};

    dxe_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .cmd_in    (cmd_in),
        .ext_ready (ext_ready),
        .ext_end   (ext_end),
        .run_q     (run_q),
        .cur       (cur),
        .launch    (launch),
        .beat      (beat),
        .finish    (finish),
        .busy      (busy)
    );

    dxe_addr_unit u_addr (
        .clk        (clk),
        .rst        (rst),
        .addr_wr    (addr_wr),
        .addr_sel   (addr_sel),
        .addr_val   (addr_val),
        .launch     (launch),
        .launch_dir (cmd_in.dir),
        .beat       (beat),
        .finish     (finish),
        .cur        (cur),
        .run_addr   (run_addr),
        .rd_base    (rd_base),
        .wr_base    (wr_base)
    );

    dxe_bank_ram u_ram (
        .clk        (clk),
        .rst        (rst),
        .ctr_wr     (ctr_wr),
        .ctr_bank   (ctr_bank),
        .ctr_val    (ctr_val),
        .beat       (beat),
        .cur        (cur),
        .ext_rdata  (ext_rdata),
        .host_we    (host_we),
        .host_bank  (host_bank),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rbank (host_rbank),
        .host_raddr (host_raddr),
        .host_rdata (host_rdata),
        .dma_rdata  (dma_rdata),
        .cur_ptr    (cur_ptr)
    );

    assign ext_addr  = run_addr;
    assign ext_wdata = dma_rdata;
    assign ext_wr_en = beat & (cur.dir == DIR_RAM_TO_EXT);
endmodule

// File: rtl/dxe_checker.sv
module dxe_checker
    import dxe_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run_q,
    input xfer_cmd_t        cur,
    input logic             cmd_start,
    input logic             ext_ready,
    input logic             ext_end,
    input logic             addr_wr,
    input logic             ext_wr_en,
    input logic [AW-1:0]    run_addr,
    input logic [AW-1:0]    rd_base,
    input logic [AW-1:0]    wr_base,
    input logic [PTR_W-1:0] cur_ptr
);
    AST_START_RAISES: assert property (@(posedge clk) disable iff (rst)
        (!run_q && cmd_start) |=> run_q); // R1

    AST_END_STOPS: assert property (@(posedge clk) disable iff (rst)
        (run_q && ext_end) |=> !run_q); // R3

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (run_q && ext_ready && !ext_end) |=> cur_ptr == $past(cur_ptr) + PTR_W'(1)); // R4

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (run_q && ext_ready && !ext_end) |=>
        run_addr == $past(run_addr) + step_bytes($past(cur.step))); // R5

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (run_q && ext_end && cur.hold && !addr_wr) |=>
        ($stable(rd_base) && $stable(wr_base))); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (run_q && cmd_start && !ext_end) |=> (cur == $past(cur))); // R10

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !ext_wr_en); // R11
endmodule

bind dram_xfer_engine dxe_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_q     (run_q),
    .cur       (cur),
    .cmd_start (cmd_start),
    .ext_ready (ext_ready),
    .ext_end   (ext_end),
    .addr_wr   (addr_wr),
    .ext_wr_en (ext_wr_en),
    .run_addr  (run_addr),
    .rd_base   (rd_base),
    .wr_base   (wr_base),
    .cur_ptr   (cur_ptr)
);

// File: tb/dram_xfer_engine_test.sv
module dram_xfer_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctr_wr = 0, addr_wr = 0, addr_sel = 0, cmd_start = 0, cmd_dir = 0;
    logic        cmd_hold = 0, ext_ready = 0, ext_end = 0, host_we = 0;
    logic [1:0]  ctr_bank = 0, cmd_bank = 0, host_bank = 0, host_rbank = 0;
    logic [5:0]  ctr_val = 0, host_addr = 0, host_raddr = 0;
    logic [2:0]  cmd_step = 0;
    logic [31:0] addr_val = 0, ext_rdata = 0, host_wdata = 0;
    logic [31:0] host_rdata, ext_addr, ext_wdata, rd_base, wr_base;
    logic        ext_wr_en, busy;

    int total = 0;
    int bad   = 0;
    string ram_tag  = "R2";
    string addr_tag = "R5";

    // bench model
    logic [31:0] m_ram [4][64];
    logic [5:0]  m_ctr [4];
    logic [31:0] m_rd = 0, m_wr = 0, m_addr = 0;
    logic        m_run = 0, m_dir = 0, m_hold = 0;
    logic [1:0]  m_bank = 0;
    logic [2:0]  m_step = 0;

    always #5 clk = ~clk;

    dram_xfer_engine uut (.*);

    function automatic logic [31:0] exp_step(input logic [2:0] code);
        case (code)
            3'd0: return 32'd0;
            3'd1: return 32'd1;
            3'd2: return 32'd2;
            3'd3: return 32'd4;
            3'd4: return 32'd8;
            3'd5: return 32'd16;
            3'd6: return 32'd32;
            default: return 32'd64;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Called right after a negedge with inputs set; checks, clocks, updates model.
    task automatic tick();
        logic bt, fin, lau;
        logic [31:0] old_rd, old_wr;
        #1;
        bt  = m_run && ext_ready && !ext_end;
        fin = m_run && ext_end;
        lau = cmd_start && !m_run;
        check(fin ? "R3" : "R1", "busy", {31'd0, busy}, {31'd0, m_run && !ext_end});
        check(m_run ? "R2" : "R11", "ext_wr_en", {31'd0, ext_wr_en}, {31'd0, bt && m_dir});
        if (bt) check(addr_tag, "ext_addr", ext_addr, m_addr);
        if (bt && m_dir) check("R2", "ext_wdata", ext_wdata, m_ram[m_bank][m_ctr[m_bank]]);
        check("R8", "rd_base", rd_base, m_rd);
        check("R8", "wr_base", wr_base, m_wr);
        check(ram_tag, "host_rdata", host_rdata, m_ram[host_rbank][host_raddr]);
        @(posedge clk);
        old_rd = m_rd; old_wr = m_wr;
        if (host_we && !(bt && !m_dir && host_bank == m_bank))
            m_ram[host_bank][host_addr] = host_wdata;
        if (ctr_wr && !(bt && ctr_bank == m_bank))
            m_ctr[ctr_bank] = ctr_val;
        if (addr_wr && !addr_sel) m_rd = addr_val;
        if (addr_wr &&  addr_sel) m_wr = addr_val;
        if (bt) begin
            if (!m_dir) m_ram[m_bank][m_ctr[m_bank]] = ext_rdata;
            m_ctr[m_bank] = m_ctr[m_bank] + 6'd1;
            m_addr = m_addr + exp_step(m_step);
        end
        if (fin) begin
            m_run = 0;
            if (!m_hold) begin
                if (m_dir) m_wr = m_addr; else m_rd = m_addr;
            end
        end else if (lau) begin
            m_run = 1; m_dir = cmd_dir; m_bank = cmd_bank;
            m_step = cmd_step; m_hold = cmd_hold;
            m_addr = cmd_dir ? old_wr : old_rd;
        end
        @(negedge clk);
        ctr_wr = 0; addr_wr = 0; cmd_start = 0; ext_ready = 0;
        ext_end = 0; host_we = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic load_ctr(input logic [1:0] b, input logic [5:0] v);
        ctr_wr = 1; ctr_bank = b; ctr_val = v; tick();
    endtask

    task automatic load_base(input logic sel, input logic [31:0] v);
        addr_wr = 1; addr_sel = sel; addr_val = v; tick();
    endtask

    task automatic start(input logic d, input logic [1:0] b,
                         input logic [2:0] s, input logic h);
        cmd_start = 1; cmd_dir = d; cmd_bank = b; cmd_step = s; cmd_hold = h; tick();
    endtask

    task automatic beat();
        ext_ready = 1; ext_rdata = $urandom; tick();
    endtask

    task automatic finish_xfer();
        ext_end = 1; ext_ready = $urandom_range(0, 1); tick();
    endtask

    task automatic sweep(input string tag);
        ram_tag = tag;
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 64; a++) begin
                host_rbank = 2'(b); host_raddr = 6'(a); tick();
            end
        ram_tag = "R2";
    endtask

    task automatic xfer(input logic d, input logic [1:0] b, input logic [2:0] s,
                        input logic h, input int n);
        start(d, b, s, h);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            beat();
        end
        finish_xfer();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4417));
        for (int b = 0; b < 4; b++) m_ctr[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R12: reset state
        check("R12", "busy after reset", {31'd0, busy}, 32'd0);
        check("R12", "rd_base after reset", rd_base, 32'd0);
        check("R12", "wr_base after reset", wr_base, 32'd0);
        // fill RAM through host port
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 64; a++) begin
                host_we = 1; host_bank = 2'(b); host_addr = 6'(a);
                host_wdata = {8'(b), 8'(a), 16'hC3A5};
                tick();
            end
        // R12: counters start at zero -> first read transfer lands at word 0
        load_base(0, 32'h1000);
        xfer(0, 2'd2, 3'd3, 0, 2);
        host_rbank = 2; host_raddr = 0; ram_tag = "R12"; tick(); ram_tag = "R2";
        // R11: ready while idle is ignored
        beat(); beat();
        sweep("R11");
        // R7: read base vs write base selection
        addr_tag = "R7";
        load_base(0, 32'h2000_0000);
        load_base(1, 32'h3000_0000);
        xfer(1, 2'd0, 3'd2, 1, 3);
        xfer(0, 2'd1, 3'd2, 1, 3);
        // R4/R9: preload near top, wrap over 63->0
        addr_tag = "R5";
        load_ctr(2'd3, 6'd62);
        xfer(0, 2'd3, 3'd7, 0, 4);
        sweep("R4");
        load_ctr(2'd3, 6'd62);
        xfer(1, 2'd3, 3'd1, 0, 4);
        load_ctr(2'd1, 6'd40);
        xfer(0, 2'd1, 3'd4, 0, 3);
        sweep("R9");
        // R6: every step code, both directions
        addr_tag = "R6";
        for (int s = 0; s < 8; s++) begin
            xfer(0, 2'(s), 3'(s), 0, 3);
            xfer(1, 2'(s), 3'(s), 1, 3);
        end
        // R10: start while busy ignored
        addr_tag = "R10";
        load_base(1, 32'h0000_8000);
        start(1, 2'd2, 3'd5, 0);
        beat();
        start(0, 2'd1, 3'd1, 1);
        beat();
        start(1, 2'd3, 3'd0, 1);
        beat();
        finish_xfer();
        check("R10", "wr_base after ignored starts", wr_base, m_wr);
        // R8: writeback vs hold
        addr_tag = "R5";
        load_base(0, 32'h0000_4000);
        xfer(0, 2'd0, 3'd4, 1, 5);
        check("R8", "hold keeps rd_base", rd_base, 32'h0000_4000);
        xfer(0, 2'd0, 3'd4, 0, 5);
        check("R8", "writeback rd_base", rd_base, 32'h0000_4028);
        // random mix
        for (int t = 0; t < 60; t++) begin
            if ($urandom_range(0, 1) == 1) load_ctr(2'($urandom), 6'($urandom));
            if ($urandom_range(0, 2) == 0) load_base(1'($urandom), $urandom);
            if ($urandom_range(0, 4) == 0) beat();
            xfer(1'($urandom), 2'($urandom), 3'($urandom), 1'($urandom),
                 $urandom_range(0, 12));
            if (t % 20 == 19) sweep("R2");
        end
        sweep("R2");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule